// File: doc/BRIEF.md
# I2C Serial Clock Phase Divider

This block generates the serial clock timing for an I2C master from a fast input clock. It works in two stages. A prescaler divides the input clock down to a slower module tick. A phase counter, counting module ticks, then measures out the low and high parts of each serial clock period. Each phase is stretched by a fixed offset that depends on the prescaler setting. The block drives a request to pull the clock line low, and two single-cycle strobes. Bit-level logic uses those strobes to move SDA while the clock is low and to sample it while the clock is high.

Two controls gate the block. The first is a module-run input, which is the release from module reset. While it is low, the block copies the three divider values into its own registers. Once it goes high, those copies are frozen. The second is a clock enable. When either control is low, the clock line is released and every counter is cleared.

Top module: `scl_phase_divider`

## Requirements
- R1: After the chip reset, `sclLowReq`, `lowEndTick` and `highEndTick` are all 0 for as long as the block is not running.
- R2: A low phase keeps `sclLowReq` at 1 for exactly (lowCount + d) * (prescale + 1) input clock cycles.
- R3: A high phase keeps `sclLowReq` at 0 for exactly (highCount + d) * (prescale + 1) input clock cycles, and the next low phase follows right after it.
- R4: The offset d is 7 when prescale is 0, 6 when prescale is 1, and 5 for any prescale of 2 or more.
- R5: The first clock edge at which `moduleRun` and `sclEnable` are both 1 starts a low phase. From that edge on, `sclLowReq` reads 1, so every period opens with its low phase.
- R6: `lowEndTick` is 1 only in the last input cycle of a low phase, and `highEndTick` is 1 only in the last input cycle of a high phase. The two are never 1 together.
- R7: Clearing `sclEnable` makes `sclLowReq` 0 and keeps both strobes at 0 from the next clock edge on. Setting it again starts a fresh low phase of full length.
- R8: The divider values are captured only while `moduleRun` is 0. Changes on `prescale`, `lowCount` or `highCount` while it is 1 leave the phase lengths unchanged until the next time `moduleRun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous chip reset, active low |
| moduleRun | input | 1 | Module reset release. While 0, the divider values are captured and clock generation stops |
| sclEnable | input | 1 | Clock generation enable |
| prescale | input | PSC_W | Prescaler value; the module tick is every prescale+1 input cycles |
| lowCount | input | CNT_W | Low phase count, before the offset is added |
| highCount | input | CNT_W | High phase count, before the offset is added |
| sclLowReq | output | 1 | 1 requests that SCL be driven low; 0 releases it |
| lowEndTick | output | 1 | Strobe in the final cycle of a low phase |
| highEndTick | output | 1 | Strobe in the final cycle of a high phase |

## Verification
`sclLowReq` is registered, so it changes one input clock edge after the condition that causes it. It rises on the first edge that sees both controls high, and it falls on the edge that follows a clear of either control. The strobes are combinational and appear in the final cycle of their phase. The bench therefore expects each strobe to be 1 in the same sampled cycle as the last cycle of its phase, and expects `sclLowReq` to flip at the sample after that. All sampling happens on the falling edge, and each phase length is counted in falling-edge samples against the formula with the offset d worked out independently from prescale.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic clear;
    logic loadLow;
    logic loadHigh;
    logic counting;
  } ctl_t;

  function automatic logic [2:0] phaseOffset(input int unsigned psc);
    if (psc == 0)      return 3'd7;
    else if (psc == 1) return 3'd6;
    else               return 3'd5;
  endfunction

endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             moduleRun,
  input  logic [PSC_W-1:0] prescale,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  ctl_t             ctl,
  output logic             modTick,
  output logic             phaseDone
);
  localparam int PH_W = CNT_W + 1;

  logic [PSC_W-1:0] pscReg;
  logic [CNT_W-1:0] lowReg;
  logic [CNT_W-1:0] highReg;
  logic [PSC_W-1:0] pscCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic [PH_W-1:0]  dVal;
  logic [PH_W-1:0]  lowLoad;
  logic [PH_W-1:0]  highLoad;

  // Shadow copies of the divider settings, writable only while held in module reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscReg  <= '0;
      lowReg  <= '0;
      highReg <= '0;
    end else if (!moduleRun) begin
      pscReg  <= prescale;
      lowReg  <= lowCount;
      highReg <= highCount;
    end
  end

  assign dVal     = PH_W'(phaseOffset(32'(pscReg)));
  assign lowLoad  = PH_W'(lowReg) + dVal - PH_W'(1);
  assign highLoad = PH_W'(highReg) + dVal - PH_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt   <= '0;
      phaseCnt <= '0;
    end else if (ctl.clear) begin
      pscCnt   <= '0;
      phaseCnt <= '0;
    end else if (ctl.loadLow) begin
      pscCnt   <= pscReg;
      phaseCnt <= lowLoad;
    end else if (ctl.loadHigh) begin
      pscCnt   <= pscReg;
      phaseCnt <= highLoad;
    end else if (ctl.counting) begin
      if (pscCnt == '0) begin
        pscCnt <= pscReg;
        if (phaseCnt != '0) phaseCnt <= phaseCnt - PH_W'(1);
      end else begin
        pscCnt <= pscCnt - PSC_W'(1);
      end
    end
  end

  assign modTick   = ctl.counting && (pscCnt == '0);
  assign phaseDone = modTick && (phaseCnt == '0);

  // R8: settings frozen while running
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (moduleRun && $past(moduleRun)) |-> ($stable(lowReg) && $stable(highReg) && $stable(pscReg)));

  // R2: the phase counter never exceeds the larger reload value
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rstN)
    (moduleRun && $past(moduleRun)) |-> (phaseCnt <= ((lowLoad > highLoad) ? lowLoad : highLoad)));

endmodule

// File: rtl/scl_div_control.sv
module scl_div_control
  import scl_div_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic moduleRun,
  input  logic sclEnable,
  input  logic phaseDone,
  output ctl_t ctl,
  output logic sclLowReq,
  output logic lowEndTick,
  output logic highEndTick
);
  phase_e state;
  phase_e nextState;
  logic   active;

  assign active = moduleRun && sclEnable;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      PH_IDLE: begin
        ctl.clear = !active;
        if (active) begin
          nextState   = PH_LOW;
          ctl.loadLow = 1'b1;
        end
      end
      PH_LOW: begin
        ctl.counting = 1'b1;
        if (!active) begin
          nextState = PH_IDLE;
          ctl.clear = 1'b1;
        end else if (phaseDone) begin
          nextState    = PH_HIGH;
          ctl.loadHigh = 1'b1;
        end
      end
      PH_HIGH: begin
        ctl.counting = 1'b1;
        if (!active) begin
          nextState = PH_IDLE;
          ctl.clear = 1'b1;
        end else if (phaseDone) begin
          nextState   = PH_LOW;
          ctl.loadLow = 1'b1;
        end
      end
      default: begin
        nextState = PH_IDLE;
        ctl.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  assign sclLowReq   = (state == PH_LOW);
  assign lowEndTick  = (state == PH_LOW)  && active && phaseDone;
  assign highEndTick = (state == PH_HIGH) && active && phaseDone;

  // R6: strobes are exclusive
  a_r6_tick_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowEndTick, highEndTick}));

  // R6: a low-end strobe closes the low phase
  a_r6_low_tick_ends: assert property (@(posedge clk) disable iff (!rstN)
    lowEndTick |=> !sclLowReq);

endmodule

// File: rtl/scl_phase_divider.sv
module scl_phase_divider
  import scl_div_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             moduleRun,
  input  logic             sclEnable,
  input  logic [PSC_W-1:0] prescale,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  output logic             sclLowReq,
  output logic             lowEndTick,
  output logic             highEndTick
);
  ctl_t ctl;
  logic modTick;
  logic phaseDone;

  scl_div_datapath #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .moduleRun (moduleRun),
    .prescale  (prescale),
    .lowCount  (lowCount),
    .highCount (highCount),
    .ctl       (ctl),
    .modTick   (modTick),
    .phaseDone (phaseDone)
  );

  scl_div_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .moduleRun   (moduleRun),
    .sclEnable   (sclEnable),
    .phaseDone   (phaseDone),
    .ctl         (ctl),
    .sclLowReq   (sclLowReq),
    .lowEndTick  (lowEndTick),
    .highEndTick (highEndTick)
  );

  // R7 / R8: an inactive block releases the line at the next edge
  a_r7_release_on_disable: assert property (@(posedge clk) disable iff (!rstN)
    !(moduleRun && sclEnable) |=> (!sclLowReq && !lowEndTick && !highEndTick));

  // R3: a high phase that ends while active hands over to a low phase
  a_r3_high_to_low: assert property (@(posedge clk) disable iff (!rstN)
    (highEndTick && moduleRun && sclEnable) |=> sclLowReq);

  // R5: activation from idle starts with the low phase
  a_r5_low_first: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLowReq && !$past(sclLowReq) && moduleRun && sclEnable && !highEndTick && !$past(highEndTick) && $past(!(moduleRun && sclEnable))) |=> sclLowReq);

endmodule

// File: tb/scl_phase_divider_bench.sv
module scl_phase_divider_bench;
  localparam int PSC_W = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             moduleRun = 1'b0;
  logic             sclEnable = 1'b0;
  logic [PSC_W-1:0] prescale = '0;
  logic [CNT_W-1:0] lowCount = '0;
  logic [CNT_W-1:0] highCount = '0;
  logic             sclLowReq;
  logic             lowEndTick;
  logic             highEndTick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  scl_phase_divider #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_scl_phase_divider (
    .clk(clk), .rstN(rstN), .moduleRun(moduleRun), .sclEnable(sclEnable),
    .prescale(prescale), .lowCount(lowCount), .highCount(highCount),
    .sclLowReq(sclLowReq), .lowEndTick(lowEndTick), .highEndTick(highEndTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int offsetOf(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  // Count negedge samples at the given level; report the sample index of the strobe
  task automatic measurePhase(input bit level, output int len, output int tickAt, output int badTick);
    len = 0; tickAt = -1; badTick = 0;
    while (sclLowReq == level && len < 5000) begin
      len++;
      if (level && lowEndTick) tickAt = len;
      if (!level && highEndTick) tickAt = len;
      if (level && highEndTick) badTick++;
      if (!level && lowEndTick) badTick++;
      if (lowEndTick && highEndTick) badTick++;
      @(negedge clk);
    end
  endtask

  task automatic configure(input int p, input int l, input int h);
    @(negedge clk);
    moduleRun = 1'b0; sclEnable = 1'b0;
    prescale = PSC_W'(p); lowCount = CNT_W'(l); highCount = CNT_W'(h);
    @(negedge clk);
    @(negedge clk);
    moduleRun = 1'b1; sclEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic testPeriod(input int p, input int l, input int h);
    int len, tickAt, bad, expLow, expHigh;
    expLow  = (l + offsetOf(p)) * (p + 1);
    expHigh = (h + offsetOf(p)) * (p + 1);
    configure(p, l, h);
    check(sclLowReq == 1'b1, "R5 low phase first", int'(sclLowReq), 1);
    for (int k = 0; k < 2; k++) begin
      measurePhase(1'b1, len, tickAt, bad);
      check(len == expLow, "R2/R4 low length", len, expLow);
      check(tickAt == len, "R6 low strobe last cycle", tickAt, len);
      check(bad == 0, "R6 stray strobe in low", bad, 0);
      measurePhase(1'b0, len, tickAt, bad);
      check(len == expHigh, "R3/R4 high length", len, expHigh);
      check(tickAt == len, "R6 high strobe last cycle", tickAt, len);
      check(bad == 0, "R6 stray strobe in high", bad, 0);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!sclLowReq && !lowEndTick && !highEndTick, "R1 reset state",
          int'({sclLowReq, lowEndTick, highEndTick}), 0);
    moduleRun = 1'b1;
    repeat (4) @(negedge clk);
    check(!sclLowReq, "R1 idle without enable", int'(sclLowReq), 0);
  endtask

  task automatic testDisable();
    int len, tickAt, bad, expLow, quiet;
    expLow = (3 + offsetOf(2)) * 3;
    configure(2, 3, 4);
    repeat (5) @(negedge clk);
    sclEnable = 1'b0;
    @(negedge clk);
    check(!sclLowReq, "R7 released after disable", int'(sclLowReq), 0);
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      if (sclLowReq || lowEndTick || highEndTick) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R7 quiet while disabled", quiet, 0);
    sclEnable = 1'b1;
    @(negedge clk);
    check(sclLowReq, "R7 restart low", int'(sclLowReq), 1);
    measurePhase(1'b1, len, tickAt, bad);
    check(len == expLow, "R7 full low after restart", len, expLow);
  endtask

  task automatic testShadow();
    int len, tickAt, bad, oldLow, newLow;
    oldLow = (2 + offsetOf(1)) * 2;
    newLow = (9 + offsetOf(1)) * 2;
    configure(1, 2, 2);
    lowCount = CNT_W'(9);
    measurePhase(1'b1, len, tickAt, bad);
    measurePhase(1'b0, len, tickAt, bad);
    measurePhase(1'b1, len, tickAt, bad);
    check(len == oldLow, "R8 change ignored while running", len, oldLow);
    moduleRun = 1'b0;
    @(negedge clk);
    check(!sclLowReq, "R8 module reset releases line", int'(sclLowReq), 0);
    @(negedge clk);
    moduleRun = 1'b1;
    @(negedge clk);
    measurePhase(1'b1, len, tickAt, bad);
    check(len == newLow, "R8 new value after module reset", len, newLow);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testPeriod(0, 1, 2);
    testPeriod(1, 0, 3);
    testPeriod(3, 2, 1);
    testDisable();
    testShadow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule